// File: doc/BRIEF.md
# Dual-Clock FIFO with Read-Side Width Conversion

This block is a first-in first-out buffer that sits between two unrelated clock domains. The producer side stores 36-bit long words. The consumer side can take each long word whole, as two 18-bit halves, or as four 9-bit lanes. The read-side width is picked on a mode input. Writes and reads are each gated by an enable, an active-low select, a direction bit and a side-channel select. An access happens only when all four agree and the FIFO is able to take it.

Each side keeps a binary pointer and a Gray-coded copy of it. The Gray copy crosses to the other side through a two-flop synchroniser. A fill level is then computed locally from the local pointer and the synchronised remote one. The producer side derives a full flag and an active-low almost-full flag from this level. The consumer side derives an empty flag and an active-low almost-empty flag. Levels count whole long words. In a narrow mode an entry is released only by the read of its final piece.

A small state machine on the read side tracks the piece of the head entry that comes next. It has four states: POS_0, POS_1, POS_2 and POS_3. In 36-bit mode it stays in POS_0. In 18-bit mode an accepted read moves POS_0→POS_1, and the next read moves POS_1→POS_0 and releases the entry. In 9-bit mode accepted reads step POS_0→POS_1→POS_2→POS_3, and the read taken in POS_3 returns to POS_0 and releases the entry. Any read on the final piece of the current mode returns the machine to POS_0.

Top module: `xfifo_busmatch`

## Requirements
- R1: A write is stored on a rising `a_clk` edge only when all of these hold: `a_en`=1, `a_sel_n`=0, `a_dir_wr`=1, `a_mbox`=0 and `a_full`=0. Any other combination stores nothing.
- R2: A read is accepted on a rising `b_clk` edge only when all of these hold: `b_en`=1, `b_sel_n`=0, `b_dir_rd`=1, `b_mbox`=0 and `b_empty`=0. An accepted read loads `b_data` on that same edge. With any other combination, `b_data` keeps its value.
- R3: With `b_mode`=2'b00, each read returns a whole long word, and long words come out in the order they were written. Code 2'b11 behaves the same way.
- R4: With `b_mode`=2'b01, a long word is returned as bits [35:18] first and then bits [17:0]. Each half appears on `b_data[17:0]` with `b_data[35:18]`=0.
- R5: With `b_mode`=2'b10, a long word is returned as bits [35:27], then [26:18], then [17:9], then [8:0]. Each lane appears on `b_data[8:0]` with the upper bits 0.
- R6: `a_full` is 1 while 2^ADDR_W entries are held. A write attempted while full leaves the stored contents unchanged.
- R7: `b_empty` is 1 while no entry is held. A read attempted while empty leaves `b_data` and the read position unchanged.
- R8: Once the levels have crossed, `a_afull_n` is 0 when the level is at least 2^ADDR_W−AF_OFS. It is 1 when the level is 2^ADDR_W−AF_OFS−1 or lower.
- R9: Once the levels have crossed, `b_aempty_n` is 0 when the level is AE_OFS or lower. It is 1 when the level is AE_OFS+1 or higher.
- R10: In a narrow mode, reads of pieces other than the last one do not change the level or any flag. The read of the last piece releases the entry.
- R11: While `rst_n`=0 and after its release with no traffic, the outputs are `a_full`=0, `a_afull_n`=1, `b_empty`=1, `b_aempty_n`=0 and `b_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| a_clk | input | 1 | Producer clock |
| a_en | input | 1 | Producer enable |
| a_sel_n | input | 1 | Producer select, active low |
| a_dir_wr | input | 1 | Producer direction, 1 = write |
| a_mbox | input | 1 | Producer side-channel select, must be 0 for FIFO writes |
| a_data | input | 36 | Long word to store |
| a_full | output | 1 | Buffer full, in the `a_clk` domain |
| a_afull_n | output | 1 | Almost full, active low, in the `a_clk` domain |
| b_clk | input | 1 | Consumer clock |
| b_en | input | 1 | Consumer enable |
| b_sel_n | input | 1 | Consumer select, active low |
| b_dir_rd | input | 1 | Consumer direction, 1 = read |
| b_mbox | input | 1 | Consumer side-channel select, must be 0 for FIFO reads |
| b_mode | input | 2 | Read width: 00 = 36-bit, 01 = 18-bit, 10 = 9-bit, 11 = 36-bit |
| b_data | output | 36 | Read output register, narrow pieces right-aligned |
| b_empty | output | 1 | Buffer empty, in the `b_clk` domain |
| b_aempty_n | output | 1 | Almost empty, active low, in the `b_clk` domain |

## Verification
Two events can land in the same cycle: a write is accepted or refused at the full boundary while a read in the other domain is freeing an entry, and a read is accepted or refused at the empty boundary while a write is arriving. Two random phases provoke both. The first pushes much faster than it pops, so the buffer saturates. The second reverses the rates, so the buffer runs dry. Each side decides acceptance from the flag it sees at that moment. Every returned word is compared with a reference queue, so a write that was lost, duplicated or wrongly accepted, or a read that was wrongly taken, shows up as a data mismatch or as a leftover entry.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 4;
    localparam int LONG_W = LANE_W * LANES;
    localparam int HALF_W = LONG_W / 2;

    typedef enum logic [1:0] {
        BM_LONG = 2'b00,
        BM_HALF = 2'b01,
        BM_BYTE = 2'b10,
        BM_RSVD = 2'b11
    } bmode_t;

    typedef enum logic [1:0] {
        POS_0 = 2'd0,
        POS_1 = 2'd1,
        POS_2 = 2'd2,
        POS_3 = 2'd3
    } pos_t;

    // lane k counted from the most significant end, right-aligned
    function automatic logic [LONG_W-1:0] lane_of(input logic [LONG_W-1:0] w, input int unsigned k);
        return LONG_W'(w[LONG_W-1-k*LANE_W -: LANE_W]);
    endfunction

    function automatic logic [LONG_W-1:0] upper_of(input logic [LONG_W-1:0] w);
        return LONG_W'(w[LONG_W-1 -: HALF_W]);
    endfunction

    function automatic logic [LONG_W-1:0] lower_of(input logic [LONG_W-1:0] w);
        return LONG_W'(w[HALF_W-1:0]);
    endfunction
endpackage

// File: rtl/xfifo_sync2.sv
`timescale 1ns/1ps
module xfifo_sync2 #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/xfifo_store.sv
`timescale 1ns/1ps
module xfifo_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/xfifo_wr_ctl.sv
`timescale 1ns/1ps
module xfifo_wr_ctl #(
    parameter int ADDR_W = 8,
    parameter int AF_OFS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [ADDR_W:0]   rd_gray_sync,
    output logic              push_ok,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0]   wr_gray,
    output logic              full,
    output logic              afull_n
);
    localparam int PW       = ADDR_W + 1;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int AF_LEVEL = DEPTH - AF_OFS;

    logic [ADDR_W:0] wr_bin_q;
    logic [ADDR_W:0] wr_bin_nxt;
    logic [ADDR_W:0] rd_bin_sync;
    logic [ADDR_W:0] level;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            rd_bin_sync[i] = ^(rd_gray_sync >> i);
        end
    end

    assign level      = wr_bin_q - rd_bin_sync;
    assign full       = (level == PW'(DEPTH));
    assign afull_n    = (level < PW'(AF_LEVEL));
    assign push_ok    = push_req & ~full;
    assign wr_bin_nxt = wr_bin_q + PW'(1);
    assign wr_addr    = wr_bin_q[ADDR_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_bin_q <= '0;
            wr_gray  <= '0;
        end else if (push_ok) begin
            wr_bin_q <= wr_bin_nxt;
            wr_gray  <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
        end
    end
endmodule

// File: rtl/xfifo_rd_ctl.sv
`timescale 1ns/1ps
module xfifo_rd_ctl
    import xfifo_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int AE_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop_req,
    input  bmode_t            mode,
    input  logic [ADDR_W:0]   wr_gray_sync,
    input  logic [LONG_W-1:0] head_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   rd_gray,
    output logic              empty,
    output logic              aempty_n,
    output logic [LONG_W-1:0] rdata,
    output pos_t              pos
);
    localparam int PW = ADDR_W + 1;

    logic [ADDR_W:0]   rd_bin_q;
    logic [ADDR_W:0]   rd_bin_nxt;
    logic [ADDR_W:0]   wr_bin_sync;
    logic [ADDR_W:0]   level;
    logic              pop_ok;
    logic              last;
    logic [LONG_W-1:0] piece;
    pos_t              pos_q;
    pos_t              pos_d;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            wr_bin_sync[i] = ^(wr_gray_sync >> i);
        end
    end

    assign level      = wr_bin_sync - rd_bin_q;
    assign empty      = (level == '0);
    assign aempty_n   = (level > PW'(AE_OFS));
    assign pop_ok     = pop_req & ~empty;
    assign rd_bin_nxt = rd_bin_q + PW'(1);
    assign rd_addr    = rd_bin_q[ADDR_W-1:0];
    assign pos        = pos_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= POS_0;
        end else begin
            pos_q <= pos_d;
        end
    end

    // next state
    always_comb begin
        pos_d = pos_q;
        if (pop_ok) begin
            if (last) begin
                pos_d = POS_0;
            end else begin
                unique case (pos_q)
                    POS_0: pos_d = POS_1;
                    POS_1: pos_d = POS_2;
                    POS_2: pos_d = POS_3;
                    POS_3: pos_d = POS_0;
                endcase
            end
        end
    end

    // outputs of the state: selected piece and last-piece indication
    always_comb begin
        last  = 1'b1;
        piece = head_word;
        unique case (pos_q)
            POS_0: begin
                if (mode == BM_HALF) begin
                    last  = 1'b0;
                    piece = upper_of(head_word);
                end else if (mode == BM_BYTE) begin
                    last  = 1'b0;
                    piece = lane_of(head_word, 0);
                end
            end
            POS_1: begin
                if (mode == BM_HALF) begin
                    piece = lower_of(head_word);
                end else if (mode == BM_BYTE) begin
                    last  = 1'b0;
                    piece = lane_of(head_word, 1);
                end
            end
            POS_2: begin
                if (mode == BM_HALF) begin
                    piece = lower_of(head_word);
                end else if (mode == BM_BYTE) begin
                    last  = 1'b0;
                    piece = lane_of(head_word, 2);
                end
            end
            POS_3: begin
                if (mode == BM_HALF) begin
                    piece = lower_of(head_word);
                end else if (mode == BM_BYTE) begin
                    piece = lane_of(head_word, 3);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_bin_q <= '0;
            rd_gray  <= '0;
            rdata    <= '0;
        end else if (pop_ok) begin
            rdata <= piece;
            if (last) begin
                rd_bin_q <= rd_bin_nxt;
                rd_gray  <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
            end
        end
    end
endmodule

// File: rtl/xfifo_busmatch.sv
`timescale 1ns/1ps
module xfifo_busmatch
    import xfifo_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int AF_OFS = 8,
    parameter int AE_OFS = 4
) (
    input  logic              rst_n,
    input  logic              a_clk,
    input  logic              a_en,
    input  logic              a_sel_n,
    input  logic              a_dir_wr,
    input  logic              a_mbox,
    input  logic [LONG_W-1:0] a_data,
    output logic              a_full,
    output logic              a_afull_n,
    input  logic              b_clk,
    input  logic              b_en,
    input  logic              b_sel_n,
    input  logic              b_dir_rd,
    input  logic              b_mbox,
    input  logic [1:0]        b_mode,
    output logic [LONG_W-1:0] b_data,
    output logic              b_empty,
    output logic              b_aempty_n
);
    localparam int PW = ADDR_W + 1;

    logic              push_req;
    logic              pop_req;
    logic              push_ok;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [PW-1:0]     wr_gray_a;
    logic [PW-1:0]     rd_gray_b;
    logic [PW-1:0]     wr_gray_b;
    logic [PW-1:0]     rd_gray_a;
    logic [LONG_W-1:0] head_word;
    pos_t              rd_pos;

    assign push_req = a_en & ~a_sel_n & a_dir_wr & ~a_mbox;
    assign pop_req  = b_en & ~b_sel_n & b_dir_rd & ~b_mbox;

    xfifo_wr_ctl #(.ADDR_W(ADDR_W), .AF_OFS(AF_OFS)) u_wr (
        .clk          (a_clk),
        .rst_n        (rst_n),
        .push_req     (push_req),
        .rd_gray_sync (rd_gray_a),
        .push_ok      (push_ok),
        .wr_addr      (wr_addr),
        .wr_gray      (wr_gray_a),
        .full         (a_full),
        .afull_n      (a_afull_n)
    );

    xfifo_sync2 #(.W(PW)) u_rd2wr (
        .clk   (a_clk),
        .rst_n (rst_n),
        .d     (rd_gray_b),
        .q     (rd_gray_a)
    );

    xfifo_sync2 #(.W(PW)) u_wr2rd (
        .clk   (b_clk),
        .rst_n (rst_n),
        .d     (wr_gray_a),
        .q     (wr_gray_b)
    );

    xfifo_store #(.ADDR_W(ADDR_W), .DATA_W(LONG_W)) u_mem (
        .clk   (a_clk),
        .we    (push_ok),
        .waddr (wr_addr),
        .wdata (a_data),
        .raddr (rd_addr),
        .rdata (head_word)
    );

    xfifo_rd_ctl #(.ADDR_W(ADDR_W), .AE_OFS(AE_OFS)) u_rd (
        .clk          (b_clk),
        .rst_n        (rst_n),
        .pop_req      (pop_req),
        .mode         (bmode_t'(b_mode)),
        .wr_gray_sync (wr_gray_b),
        .head_word    (head_word),
        .rd_addr      (rd_addr),
        .rd_gray      (rd_gray_b),
        .empty        (b_empty),
        .aempty_n     (b_aempty_n),
        .rdata        (b_data),
        .pos          (rd_pos)
    );
endmodule

// File: rtl/xfifo_busmatch_chk.sv
`timescale 1ns/1ps
module xfifo_busmatch_chk #(
    parameter int PW = 9
) (
    input logic          rst_n,
    input logic          a_clk,
    input logic          b_clk,
    input logic          a_full,
    input logic          a_afull_n,
    input logic          b_empty,
    input logic          b_aempty_n,
    input logic [PW-1:0] wr_gray,
    input logic [PW-1:0] rd_gray,
    input logic [1:0]    pos
);
    AST_NO_OVERFLOW: assert property (@(posedge a_clk) disable iff (!rst_n)
        a_full |=> $stable(wr_gray)); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge b_clk) disable iff (!rst_n)
        b_empty |=> ($stable(rd_gray) && $stable(pos))); // R7

    AST_FULL_MEANS_AFULL: assert property (@(posedge a_clk) disable iff (!rst_n)
        a_full |-> !a_afull_n); // R8

    AST_EMPTY_MEANS_AEMPTY: assert property (@(posedge b_clk) disable iff (!rst_n)
        b_empty |-> !b_aempty_n); // R9

    AST_WR_ONE_STEP: assert property (@(posedge a_clk) disable iff (!rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1); // R1

    AST_RELEASE_ON_LAST: assert property (@(posedge b_clk) disable iff (!rst_n)
        !$stable(rd_gray) |-> (pos == 2'd0)); // R10
endmodule

bind xfifo_busmatch xfifo_busmatch_chk #(.PW(ADDR_W + 1)) u_chk (
    .rst_n      (rst_n),
    .a_clk      (a_clk),
    .b_clk      (b_clk),
    .a_full     (a_full),
    .a_afull_n  (a_afull_n),
    .b_empty    (b_empty),
    .b_aempty_n (b_aempty_n),
    .wr_gray    (wr_gray_a),
    .rd_gray    (rd_gray_b),
    .pos        (rd_pos)
);

// File: tb/xfifo_busmatch_bench.sv
`timescale 1ns/1ps
module xfifo_busmatch_bench;
    localparam int ADDR_W = 8;
    localparam int AF_OFS = 8;
    localparam int AE_OFS = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic        rst_n = 1'b0;
    logic        a_clk = 1'b0;
    logic        b_clk = 1'b0;
    logic        a_en = 1'b0, a_sel_n = 1'b0, a_dir_wr = 1'b1, a_mbox = 1'b0;
    logic [35:0] a_data = '0;
    logic        b_en = 1'b0, b_sel_n = 1'b0, b_dir_rd = 1'b1, b_mbox = 1'b0;
    logic [1:0]  b_mode = 2'b00;
    logic        a_full, a_afull_n, b_empty, b_aempty_n;
    logic [35:0] b_data;

    int n_chk = 0;
    int n_err = 0;
    int bpos  = 0;
    bit done  = 1'b0;
    logic [35:0] mq[$];

    always #5 a_clk = ~a_clk;
    always #6.7 b_clk = ~b_clk;

    xfifo_busmatch #(.ADDR_W(ADDR_W), .AF_OFS(AF_OFS), .AE_OFS(AE_OFS)) u_xfifo_busmatch (
        .rst_n(rst_n), .a_clk(a_clk), .a_en(a_en), .a_sel_n(a_sel_n), .a_dir_wr(a_dir_wr),
        .a_mbox(a_mbox), .a_data(a_data), .a_full(a_full), .a_afull_n(a_afull_n),
        .b_clk(b_clk), .b_en(b_en), .b_sel_n(b_sel_n), .b_dir_rd(b_dir_rd), .b_mbox(b_mbox),
        .b_mode(b_mode), .b_data(b_data), .b_empty(b_empty), .b_aempty_n(b_aempty_n)
    );

    function automatic logic [35:0] slice_of(input logic [35:0] w, input logic [1:0] m, input int p);
        case (m)
            2'b01:   return (p == 0) ? {18'd0, w[35:18]} : {18'd0, w[17:0]};
            2'b10:   return {27'd0, w[35-9*p -: 9]};
            default: return w;
        endcase
    endfunction

    function automatic bit is_last(input logic [1:0] m, input int p);
        case (m)
            2'b01:   return p == 1;
            2'b10:   return p == 3;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [35:0] rnd_word();
        return 36'({$urandom(), $urandom()});
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input logic [35:0] d, input logic en, input logic sel_n,
                       input logic dir, input logic mbox);
        @(negedge a_clk);
        a_en = en; a_sel_n = sel_n; a_dir_wr = dir; a_mbox = mbox; a_data = d;
        @(negedge a_clk);
        a_en = 1'b0; a_sel_n = 1'b0; a_dir_wr = 1'b1; a_mbox = 1'b0;
    endtask

    task automatic put_ok(input logic [35:0] d);
        put(d, 1'b1, 1'b0, 1'b1, 1'b0);
        mq.push_back(d);
    endtask

    task automatic take(input logic sel_n, input logic dir, input logic mbox, output logic [35:0] v);
        @(negedge b_clk);
        b_en = 1'b1; b_sel_n = sel_n; b_dir_rd = dir; b_mbox = mbox;
        @(negedge b_clk);
        b_en = 1'b0; b_sel_n = 1'b0; b_dir_rd = 1'b1; b_mbox = 1'b0;
        v = b_data;
    endtask

    // read one piece in the current mode and compare against the reference queue
    task automatic get_chk(input string req);
        logic [35:0] exp;
        logic [35:0] v;
        exp = slice_of(mq[0], b_mode, bpos);
        take(1'b0, 1'b1, 1'b0, v);
        chk(req, v, exp);
        if (is_last(b_mode, bpos)) begin
            void'(mq.pop_front());
            bpos = 0;
        end else begin
            bpos++;
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge a_clk);
        repeat (6) @(posedge b_clk);
        #1;
    endtask

    task automatic run_random(input int n_a);
        fork
            begin : writer
                for (int i = 0; i < n_a; i++) begin
                    int p;
                    p = (i < n_a / 2) ? 85 : 25;
                    @(negedge a_clk);
                    a_en     = ($urandom_range(99) < p);
                    a_sel_n  = ($urandom_range(99) < 8);
                    a_dir_wr = ($urandom_range(99) >= 8);
                    a_mbox   = ($urandom_range(99) < 8);
                    a_data   = rnd_word();
                    if (a_en && !a_sel_n && a_dir_wr && !a_mbox && !a_full) mq.push_back(a_data);
                end
                @(negedge a_clk);
                a_en = 1'b0; a_sel_n = 1'b0; a_dir_wr = 1'b1; a_mbox = 1'b0;
            end
            begin : reader
                bit          pend;
                logic [35:0] exp;
                pend = 1'b0;
                exp  = '0;
                for (int i = 0; i < (n_a * 10) / 13; i++) begin
                    int p;
                    p = (i < (n_a * 5) / 13) ? 30 : 85;
                    @(negedge b_clk);
                    if (pend) chk("R3 random order", b_data, exp);
                    b_en     = ($urandom_range(99) < p);
                    b_sel_n  = ($urandom_range(99) < 8);
                    b_dir_rd = ($urandom_range(99) >= 8);
                    b_mbox   = ($urandom_range(99) < 8);
                    pend = b_en && !b_sel_n && b_dir_rd && !b_mbox && !b_empty;
                    if (pend) exp = mq.pop_front();
                end
                @(negedge b_clk);
                if (pend) chk("R3 random order", b_data, exp);
                b_en = 1'b0; b_sel_n = 1'b0; b_dir_rd = 1'b1; b_mbox = 1'b0;
            end
        join
    endtask

    initial begin : watchdog
        #1500000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        logic [35:0] v;
        logic [35:0] w;
        void'($urandom(32'd20240611));

        // R11 reset state
        repeat (4) @(posedge a_clk);
        #1;
        chk("R11 a_full in reset", 36'(a_full), 36'd0);
        chk("R11 a_afull_n in reset", 36'(a_afull_n), 36'd1);
        chk("R11 b_empty in reset", 36'(b_empty), 36'd1);
        chk("R11 b_aempty_n in reset", 36'(b_aempty_n), 36'd0);
        @(negedge a_clk);
        rst_n = 1'b1;
        settle();
        chk("R11 b_data after reset", b_data, 36'd0);
        chk("R11 b_aempty_n after reset", 36'(b_aempty_n), 36'd0);

        // R1 disqualified writes store nothing
        put(rnd_word(), 1'b1, 1'b1, 1'b1, 1'b0);
        put(rnd_word(), 1'b1, 1'b0, 1'b0, 1'b0);
        put(rnd_word(), 1'b1, 1'b0, 1'b1, 1'b1);
        put(rnd_word(), 1'b0, 1'b0, 1'b1, 1'b0);
        settle();
        chk("R1 qualified-out writes leave empty", 36'(b_empty), 36'd1);

        // R2 disqualified reads do not load b_data
        for (int i = 0; i < 3; i++) put_ok(rnd_word());
        settle();
        take(1'b1, 1'b1, 1'b0, v);
        chk("R2 read with select high", v, 36'd0);
        take(1'b0, 1'b0, 1'b0, v);
        chk("R2 read with direction low", v, 36'd0);
        take(1'b0, 1'b1, 1'b1, v);
        chk("R2 read with side-channel select", v, 36'd0);

        // R3 whole words in order
        for (int i = 0; i < 3; i++) get_chk("R3 long word order");
        settle();
        chk("R3 empty after drain", 36'(b_empty), 36'd1);

        // R7 read while empty
        w = b_data;
        take(1'b0, 1'b1, 1'b0, v);
        chk("R7 read on empty holds b_data", v, w);

        // R4 halves
        b_mode = 2'b01;
        for (int i = 0; i < 2; i++) put_ok(rnd_word());
        settle();
        for (int i = 0; i < 4; i++) get_chk("R4 half order");

        // R5 lanes
        b_mode = 2'b10;
        for (int i = 0; i < 2; i++) put_ok(rnd_word());
        settle();
        for (int i = 0; i < 8; i++) get_chk("R5 lane order");
        settle();
        chk("R5 empty after lanes", 36'(b_empty), 36'd1);

        // R9 almost-empty thresholds
        b_mode = 2'b00;
        for (int i = 0; i < AE_OFS; i++) put_ok(rnd_word());
        settle();
        chk("R9 aempty_n at AE_OFS", 36'(b_aempty_n), 36'd0);
        put_ok(rnd_word());
        settle();
        chk("R9 aempty_n at AE_OFS+1", 36'(b_aempty_n), 36'd1);

        // R10 partial lane reads keep the level
        b_mode = 2'b10;
        for (int i = 0; i < 3; i++) get_chk("R10 lane");
        settle();
        chk("R10 aempty_n after partial reads", 36'(b_aempty_n), 36'd1);
        get_chk("R10 last lane");
        settle();
        chk("R10 aempty_n after last lane", 36'(b_aempty_n), 36'd0);
        b_mode = 2'b00;
        while (mq.size() > 0) get_chk("R3 drain");

        // R8 / R6 near full
        for (int i = 0; i < DEPTH - AF_OFS - 1; i++) put_ok(rnd_word());
        settle();
        chk("R8 afull_n one below level", 36'(a_afull_n), 36'd1);
        put_ok(rnd_word());
        settle();
        chk("R8 afull_n at level", 36'(a_afull_n), 36'd0);
        for (int i = 0; i < AF_OFS; i++) put_ok(rnd_word());
        settle();
        chk("R6 a_full at depth", 36'(a_full), 36'd1);
        put(36'hF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0);
        b_mode = 2'b01;
        get_chk("R10 upper half at full");
        settle();
        chk("R10 a_full after first half", 36'(a_full), 36'd1);
        get_chk("R10 lower half at full");
        settle();
        chk("R6 a_full after release", 36'(a_full), 36'd0);
        chk("R8 afull_n at depth-1", 36'(a_afull_n), 36'd0);
        b_mode = 2'b00;
        for (int i = 0; i < AF_OFS; i++) get_chk("R6 read near full");
        settle();
        chk("R8 afull_n below level", 36'(a_afull_n), 36'd1);
        while (mq.size() > 0) get_chk("R6 no extra word stored");
        settle();
        chk("R6 empty after full drain", 36'(b_empty), 36'd1);
        w = b_data;
        take(1'b0, 1'b1, 1'b0, v);
        chk("R7 read on empty after drain", v, w);

        // random phases, full then empty pressure
        run_random(3000);
        settle();
        while (!b_empty) begin
            get_chk("R3 random drain");
            settle();
        end
        chk("R3 reference queue empty", 36'(mq.size()), 36'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule